// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock Stretching

This block is the target side of a two-wire serial bus. It watches the clock and data lines through a two-flop synchronizer and recognises START and STOP conditions. It collects a 7-bit address plus a direction bit and compares the address with a programmed value. After a match it either takes in data bytes from the bus master or sends bytes to it, and it drives the acknowledge bit where the protocol requires one. Both lines are open-drain, so the block only outputs active-low pull enables. Bytes are shifted most significant bit first.

On the processor side there is one transmit holding register and one receive holding register. Each sits in front of its own bit shift register. The processor writes the transmit register, reads the receive register, and watches flags that show when each register needs service.

When the processor falls behind, the block stretches the bus clock rather than losing data. A received byte that finds the receive register still unread holds SCL low before the acknowledge bit, until the processor reads. A byte to be sent that finds the transmit register empty holds SCL low after the acknowledge phase, until the processor writes.

Top module: `i2cs_top`

## Requirements
- R1: `busBusy` goes to 1 after a START (SDA falls while SCL is high) and returns to 0 after a STOP (SDA rises while SCL is high).
- R2: A received address byte whose upper 7 bits equal `ownAddr` is acknowledged, with SDA pulled low during the ninth clock. A non-matching address, and every byte after it up to the next START, leaves both lines released and loads nothing.
- R3: Received bytes are assembled MSB first. The matched address byte, including its direction bit in bit 0 (1 means the master reads), is placed in the receive register with `rxIsData`=0. Each data byte is placed there with `rxIsData`=1. Each load sets `rxFlag`, and each data byte is acknowledged.
- R4: `rxFlag` clears when `rxRdEn` is pulsed. While `rxFlag` is 1, the receive register keeps its contents.
- R5: If a byte completes while `rxFlag` is still 1, SCL is held low (`sclPullN`=0) from the clock fall after its eighth bit until the register is read. The new byte is then loaded and acknowledged.
- R6: A processor write fills the transmit holding register and clears `txFlag`. Moving the holding register into the shift register sets `txFlag`. Bytes go out MSB first.
- R7: If the transmit holding register is empty when a byte to send is due, SCL is held low after the acknowledge phase. A write during that stall goes straight into the shift register, releases SCL and sets `txFlag`.
- R8: During a slave transmit, the acknowledge bit from the master is latched into `rxAckFlag` (1 means no acknowledge). On a no-acknowledge, the block releases SDA and sends nothing more until the next START.
- R9: `irq` is 1 exactly when `irqEn` is 1 and `txFlag` or `rxFlag` is 1.
- R10: A repeated START without a STOP restarts address reception.
- R11: After reset, both pull enables are 1 (released) and `txFlag`, `rxFlag`, `rxAckFlag`, `busBusy` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclPullN | output | 1 | 0 pulls SCL low (clock stretch) |
| sdaPullN | output | 1 | 0 pulls SDA low |
| ownAddr | input | 7 | Programmed slave address |
| irqEn | input | 1 | Interrupt enable |
| txWrEn | input | 1 | Write strobe for the transmit holding register |
| txWrData | input | 8 | Transmit write data |
| rxRdEn | input | 1 | Read strobe, clears `rxFlag` |
| rxRdData | output | 8 | Receive holding register contents |
| txFlag | output | 1 | Transmit data moved, next byte requested |
| rxFlag | output | 1 | Receive register holds an unread byte |
| rxIsData | output | 1 | 1 when the receive register holds data, 0 when it holds the address |
| rxAckFlag | output | 1 | Last acknowledge bit sampled from the master |
| busBusy | output | 1 | Bus between START and STOP |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the bus through a master model that waits for SCL to actually rise, so it goes after both stall paths. A byte that arrives on an unread register must block the master before its acknowledge bit and must leave the old register contents intact. A design that overwrote the register, or acknowledged before the read, would show the new byte too early or let the master finish. The transmit stall is broken by a write, and that byte must be the very next one out. A design that parked the write in the holding register would hang or send a stale byte. The bench also checks that the block ignores a foreign address and the data after it, that a repeated START loads a fresh address byte, and that a master no-acknowledge releases SDA.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    stIdle, stAddr, stRecv, stAck, stStallRx,
    stSend, stSendAck, stStallTx, stIgnore
  } stateT;

  typedef struct packed {
    logic shiftIn;   // sample SDA into receive shifter
    logic shiftOut;  // advance transmit shifter
    logic loadRx;    // receive shifter -> holding register
    logic rxData;    // loaded byte is data (1) or address (0)
    logic moveTx;    // holding register -> transmit shifter
    logic directTx;  // processor write goes straight to shifter
    logic captAck;   // latch master acknowledge bit
  } strobeT;
endpackage

// File: rtl/i2cs_dp.sv
module i2cs_dp
  import i2cs_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic          txWrEn,
  input  logic [DW-1:0] txWrData,
  input  logic          rxRdEn,
  input  strobeT        strb,
  output logic          sclS,
  output logic          sclRise,
  output logic          sclFall,
  output logic          startDet,
  output logic          stopDet,
  output logic [DW-1:0] rxShift,
  output logic          txMsb,
  output logic          txFull,
  output logic          txFlag,
  output logic          rxFlag,
  output logic          rxIsData,
  output logic          rxAckFlag,
  output logic [DW-1:0] rxHold,
  output logic          busBusy
);
  logic [SYNC-1:0] sclPipe, sdaPipe;
  logic sdaS, sclQ, sdaQ;
  logic [DW-1:0] txHold, txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC-1];
  assign sdaS     = sdaPipe[SYNC-1];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign txMsb    = txShift[DW-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      rxHold    <= '0;
      rxFlag    <= 1'b0;
      rxIsData  <= 1'b0;
      txHold    <= '0;
      txShift   <= '1;
      txFull    <= 1'b0;
      txFlag    <= 1'b0;
      rxAckFlag <= 1'b0;
      busBusy   <= 1'b0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[DW-2:0], sdaS};

      if (strb.loadRx) begin
        rxHold   <= rxShift;
        rxFlag   <= 1'b1;
        rxIsData <= strb.rxData;
      end else if (rxRdEn) begin
        rxFlag <= 1'b0;
      end

      if (strb.directTx)      txShift <= txWrData;
      else if (strb.moveTx)   txShift <= txHold;
      else if (strb.shiftOut) txShift <= {txShift[DW-2:0], 1'b1};

      if (strb.directTx || strb.moveTx) begin
        txFull <= 1'b0;
        txFlag <= 1'b1;
      end
      if (txWrEn && !strb.directTx) begin
        txHold <= txWrData;
        txFull <= 1'b1;
        txFlag <= 1'b0;
      end

      if (strb.captAck) rxAckFlag <= sdaS;

      if (startDet)     busBusy <= 1'b1;
      else if (stopDet) busBusy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = DW - 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] ownAddr,
  input  logic          sclRise,
  input  logic          sclFall,
  input  logic          startDet,
  input  logic          stopDet,
  input  logic [DW-1:0] rxShift,
  input  logic          txMsb,
  input  logic          txFull,
  input  logic          rxFlag,
  input  logic          rxAckFlag,
  input  logic          txWrEn,
  output strobeT        strb,
  output logic          sclPullN,
  output logic          sdaPullN
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  stateT state, stateNx;
  logic [CW-1:0] bitCnt, cntNx;
  logic isRead, readNx, dataPh, dataNx;

  always_comb begin
    stateNx = state;
    cntNx   = bitCnt;
    readNx  = isRead;
    dataNx  = dataPh;
    strb    = '0;
    if (startDet) begin
      stateNx = stAddr;
      cntNx   = '0;
    end else if (stopDet) begin
      stateNx = stIdle;
    end else begin
      case (state)
        stAddr, stRecv: begin
          if (sclRise && bitCnt != FULL) begin
            strb.shiftIn = 1'b1;
            cntNx = bitCnt + CW'(1);
          end else if (sclFall && bitCnt == FULL) begin
            if (state == stAddr && rxShift[DW-1:1] != ownAddr) begin
              stateNx = stIgnore;
            end else begin
              if (state == stAddr) readNx = rxShift[0];
              dataNx = (state == stRecv);
              if (rxFlag) begin
                stateNx = stStallRx;
              end else begin
                strb.loadRx = 1'b1;
                strb.rxData = (state == stRecv);
                stateNx = stAck;
              end
            end
          end
        end
        stStallRx: if (!rxFlag) begin
          strb.loadRx = 1'b1;
          strb.rxData = dataPh;
          stateNx = stAck;
        end
        stAck: if (sclFall) begin
          cntNx = '0;
          if (!isRead) stateNx = stRecv;
          else if (txFull) begin
            strb.moveTx = 1'b1;
            stateNx = stSend;
          end else stateNx = stStallTx;
        end
        stStallTx: begin
          if (txWrEn) begin
            strb.directTx = 1'b1;
            stateNx = stSend;
          end else if (txFull) begin
            strb.moveTx = 1'b1;
            stateNx = stSend;
          end
        end
        stSend: if (sclFall) begin
          if (bitCnt == LAST) stateNx = stSendAck;
          else begin
            strb.shiftOut = 1'b1;
            cntNx = bitCnt + CW'(1);
          end
        end
        stSendAck: begin
          if (sclRise) strb.captAck = 1'b1;
          if (sclFall) begin
            cntNx = '0;
            if (rxAckFlag) stateNx = stIgnore;
            else if (txFull) begin
              strb.moveTx = 1'b1;
              stateNx = stSend;
            end else stateNx = stStallTx;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= stIdle;
      bitCnt <= '0;
      isRead <= 1'b0;
      dataPh <= 1'b0;
    end else begin
      state  <= stateNx;
      bitCnt <= cntNx;
      isRead <= readNx;
      dataPh <= dataNx;
    end
  end

  assign sclPullN = !(state == stStallRx || state == stStallTx);
  assign sdaPullN = !(state == stAck || state == stStallRx ||
                      (state == stSend && !txMsb));
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
  import i2cs_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2,
  localparam int AW  = DW - 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  output logic          sclPullN,
  output logic          sdaPullN,
  input  logic [AW-1:0] ownAddr,
  input  logic          irqEn,
  input  logic          txWrEn,
  input  logic [DW-1:0] txWrData,
  input  logic          rxRdEn,
  output logic [DW-1:0] rxRdData,
  output logic          txFlag,
  output logic          rxFlag,
  output logic          rxIsData,
  output logic          rxAckFlag,
  output logic          busBusy,
  output logic          irq
);
  strobeT strb;
  logic sclS, sclRise, sclFall, startDet, stopDet, txMsb, txFull;
  logic [DW-1:0] rxShift;

  i2cs_dp #(.DW(DW), .SYNC(SYNC)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .txWrEn(txWrEn), .txWrData(txWrData), .rxRdEn(rxRdEn), .strb(strb),
    .sclS(sclS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxShift(rxShift),
    .txMsb(txMsb), .txFull(txFull), .txFlag(txFlag), .rxFlag(rxFlag),
    .rxIsData(rxIsData), .rxAckFlag(rxAckFlag), .rxHold(rxRdData),
    .busBusy(busBusy)
  );

  i2cs_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ownAddr(ownAddr),
    .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxShift(rxShift),
    .txMsb(txMsb), .txFull(txFull), .rxFlag(rxFlag),
    .rxAckFlag(rxAckFlag), .txWrEn(txWrEn), .strb(strb),
    .sclPullN(sclPullN), .sdaPullN(sdaPullN)
  );

  assign irq = irqEn & (txFlag | rxFlag);
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          sclS,
  input logic          startDet,
  input logic          stopDet,
  input logic          busBusy,
  input logic          rxFlag,
  input logic          rxRdEn,
  input logic [DW-1:0] rxRdData,
  input logic          txFlag,
  input logic          txFull,
  input logic          txWrEn,
  input logic          sclPullN,
  input logic          sdaPullN
);
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> $past(startDet)); // R1
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> $past(stopDet)); // R1
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && !rxRdEn) |=> (rxFlag && $stable(rxRdData))); // R4
  AST_TX_FLAG_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFlag) |-> $past(txFull || txWrEn)); // R6
  AST_STRETCH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !sclPullN |-> !sclS); // R5
  AST_SDA_EDGE_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullN) |-> (!sclS || $past(startDet || stopDet))); // R2
endmodule

bind i2cs_top i2cs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startDet(startDet),
  .stopDet(stopDet), .busBusy(busBusy), .rxFlag(rxFlag),
  .rxRdEn(rxRdEn), .rxRdData(rxRdData), .txFlag(txFlag),
  .txFull(txFull), .txWrEn(txWrEn), .sclPullN(sclPullN),
  .sdaPullN(sdaPullN)
);

// File: tb/sim_i2cs_top.sv
module sim_i2cs_top;
  localparam int CLK_PERIOD = 10;
  localparam int QP = 10;
  localparam logic [6:0] ADDR = 7'h5A;

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclPullN, sdaPullN, irqEn = 1'b0, txWrEn = 1'b0, rxRdEn = 1'b0;
  logic [7:0] txWrData = '0, rxRdData;
  logic txFlag, rxFlag, rxIsData, rxAckFlag, busBusy, irq;
  logic sclLine, sdaLine;
  int nChk = 0, nBad = 0;
  bit done = 0;

  assign sclLine = mScl & sclPullN;
  assign sdaLine = mSda & sdaPullN;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cs_top u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullN(sclPullN), .sdaPullN(sdaPullN), .ownAddr(ADDR),
    .irqEn(irqEn), .txWrEn(txWrEn), .txWrData(txWrData),
    .rxRdEn(rxRdEn), .rxRdData(rxRdData), .txFlag(txFlag),
    .rxFlag(rxFlag), .rxIsData(rxIsData), .rxAckFlag(rxAckFlag),
    .busBusy(busBusy), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic qp();
    repeat (QP) @(negedge clk);
  endtask

  task automatic sclHigh();
    mScl = 1'b1;
    do @(negedge clk); while (!sclLine);
  endtask

  task automatic mStart();
    mSda = 1'b1; qp(); sclHigh(); qp();
    mSda = 1'b0; qp();
    mScl = 1'b0; qp();
  endtask

  task automatic mStop();
    mSda = 1'b0; qp(); sclHigh(); qp();
    mSda = 1'b1; qp();
  endtask

  task automatic mBit(input logic b, output logic r);
    mSda = b; qp(); sclHigh(); qp();
    r = sdaLine;
    mScl = 1'b0; qp();
  endtask

  task automatic mWrite(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) mBit(d[i], r);
    mBit(1'b1, r);
    ack = !r;
  endtask

  task automatic mRead(output logic [7:0] d, input logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      mBit(1'b1, r);
      d[i] = r;
    end
    mBit(!ack, r);
  endtask

  task automatic cpuWrite(input logic [7:0] d);
    @(negedge clk); txWrEn = 1'b1; txWrData = d;
    @(negedge clk); txWrEn = 1'b0;
  endtask

  task automatic cpuRead(output logic [7:0] d);
    @(negedge clk); d = rxRdData; rxRdEn = 1'b1;
    @(negedge clk); rxRdEn = 1'b0;
  endtask

  task automatic tReset();
    chk("R11 sclPullN", sclPullN, 1);
    chk("R11 sdaPullN", sdaPullN, 1);
    chk("R11 flags", {txFlag, rxFlag, rxAckFlag, busBusy, irq}, 0);
  endtask

  task automatic tWrite();
    logic ack; logic [7:0] d;
    irqEn = 1'b1;
    chk("R9 irq idle", irq, 0);
    mStart();
    chk("R1 busy after start", busBusy, 1);
    mWrite({ADDR, 1'b0}, ack);
    chk("R2 addr ack", ack, 1);
    chk("R3 addr byte", rxRdData, {ADDR, 1'b0});
    chk("R3 addr kind", {rxFlag, rxIsData}, 2'b10);
    chk("R9 irq on rx", irq, 1);
    cpuRead(d);
    chk("R4 flag cleared", rxFlag, 0);
    chk("R9 irq cleared", irq, 0);
    mWrite(8'hC3, ack);
    chk("R3 data ack", ack, 1);
    chk("R3 data byte", rxRdData, 8'hC3);
    chk("R3 data kind", {rxFlag, rxIsData}, 2'b11);
    cpuRead(d);
    mStop();
    chk("R1 idle after stop", busBusy, 0);
    irqEn = 1'b0;
  endtask

  task automatic tMismatch();
    logic ack;
    mStart();
    mWrite({ADDR ^ 7'h01, 1'b0}, ack);
    chk("R2 foreign addr nack", ack, 0);
    chk("R2 foreign addr no load", rxFlag, 0);
    mWrite(8'h00, ack);
    chk("R2 data after foreign nack", ack, 0);
    chk("R2 data after foreign no load", rxFlag, 0);
    chk("R2 lines released", {sclPullN, sdaPullN}, 2'b11);
    mStop();
  endtask

  task automatic tRxStretch();
    logic ack; logic [7:0] d;
    mStart();
    mWrite({ADDR, 1'b0}, ack);
    fork
      mWrite(8'h96, ack);
      begin
        do @(negedge clk); while (sclPullN);
        repeat (50) @(negedge clk);
        chk("R5 scl held", sclPullN, 0);
        chk("R4 old byte kept", rxRdData, {ADDR, 1'b0});
        chk("R4 old kind kept", rxIsData, 0);
        cpuRead(d);
      end
    join
    chk("R5 ack after read", ack, 1);
    chk("R5 new byte", rxRdData, 8'h96);
    chk("R5 new kind", {rxFlag, rxIsData}, 2'b11);
    cpuRead(d);
    mStop();
  endtask

  task automatic tTxPreload();
    logic ack; logic [7:0] d;
    cpuWrite(8'h81);
    chk("R6 flag cleared by write", txFlag, 0);
    mStart();
    mWrite({ADDR, 1'b1}, ack);
    chk("R2 read addr ack", ack, 1);
    chk("R6 flag set on move", txFlag, 1);
    cpuRead(d);
    chk("R3 read dir bit", d, {ADDR, 1'b1});
    mRead(d, 1'b0);
    chk("R6 byte msb first", d, 8'h81);
    chk("R8 nack latched", rxAckFlag, 1);
    chk("R8 sda released", sdaPullN, 1);
    mStop();
  endtask

  task automatic tTxStretch();
    logic ack; logic [7:0] d;
    mStart();
    mWrite({ADDR, 1'b1}, ack);
    cpuRead(d);
    repeat (40) @(negedge clk);
    chk("R7 scl held on empty", sclPullN, 0);
    cpuWrite(8'hA5);
    chk("R7 scl released", sclPullN, 1);
    chk("R7 flag set on direct", txFlag, 1);
    cpuWrite(8'h3C);
    chk("R6 flag cleared", txFlag, 0);
    mRead(d, 1'b1);
    chk("R7 stalled byte sent", d, 8'hA5);
    chk("R8 ack latched", rxAckFlag, 0);
    chk("R6 flag set on move", txFlag, 1);
    mRead(d, 1'b0);
    chk("R6 second byte", d, 8'h3C);
    chk("R8 nack latched", rxAckFlag, 1);
    repeat (QP) @(negedge clk);
    chk("R8 no stall after nack", {sclPullN, sdaPullN}, 2'b11);
    mStop();
  endtask

  task automatic tRepStart();
    logic ack; logic [7:0] d;
    mStart();
    mWrite({ADDR, 1'b0}, ack);
    cpuRead(d);
    mWrite(8'h11, ack);
    cpuRead(d);
    mStart();
    chk("R10 still busy", busBusy, 1);
    mWrite({ADDR, 1'b1}, ack);
    chk("R10 addr ack", ack, 1);
    chk("R10 addr reloaded", rxRdData, {ADDR, 1'b1});
    chk("R10 addr kind", rxIsData, 0);
    cpuRead(d);
    cpuWrite(8'h77);
    mRead(d, 1'b0);
    chk("R10 read after restart", d, 8'h77);
    mStop();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tWrite();
    tMismatch();
    tRxStretch();
    tTxPreload();
    tTxStretch();
    tRepStart();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog act=running exp=finished");
    finishRun();
  end
endmodule